// File: doc/BRIEF.md
# Pseudo-SRAM power-state sequencer

This block owns the two chip-enable pins of a pseudo-static memory while the memory is being brought up or put to sleep. After a supply-good indication it holds the second enable at the level the selected start-up method needs for a timed interval. It then raises that enable and keeps the first enable deasserted for a long recovery interval. Only after that does it raise `ready`, which lets the access controller drive normal cycles.

While running, a host power-down request is remembered and carried out as soon as the access controller reports an idle bus. The sequencer forces the first enable high, waits a short setup, drops the second enable and holds it low for a minimum time. The memory then sleeps until a wake request arrives. Waking raises the second enable after a setup interval and repeats the full recovery wait. A second start-up method holds the second enable high at power-up and then performs one complete low-power entry and exit before the first access. All intervals come from one shared down-counter. Its lengths are derived from a clock-frequency parameter given in MHz. Microsecond intervals take `us * CLK_MHZ` cycles. Nanosecond intervals take `ceil(ns * CLK_MHZ / 1000)` cycles, with a minimum of one.

Top module: `psram_pwr_seq`

## Requirements
- R1: During and after reset, and until supply-good is seen, the block drives `ce1_n`=1, `ce2`=0, `ready`=0 and `sleeping`=0. A reset applied while running returns the outputs to these values at the next clock edge.
- R2: With `alt_boot`=0, `ce2` stays 0 for exactly PWRUP_LOW_US×CLK_MHZ cycles after supply-good is first sampled high. It rises in the following cycle.
- R3: Each time `ce2` rises, `ce1_n` stays 1 and `ready` stays 0 for exactly RECOVER_US×CLK_MHZ cycles. Then `ready` rises.
- R4: `ce2` never rises while `ce1_n` is 0. Whenever `ce2` falls with supply good, `ce1_n` has been 1 for at least the setup interval.
- R5: `ready` is 1 only in the running state, where `ce2`=1 and `ce1_n` follows `host_ce1_n`. Whenever `ready` is 0, `ce1_n` is 1.
- R6: A one-cycle `pd_req` pulse is remembered. Entry to low power starts, and `ready` drops, only on a cycle where `bus_idle` is 1.
- R7: Entry holds `ce1_n`=1, `ce2`=1 for the setup interval. It then drives `ce2`=0 for the low-power hold interval, after which `sleeping`=1.
- R8: A wake request that arrives during the hold interval is kept. The block goes to sleep when the hold ends, leaves one cycle later, keeps `ce2`=0 for the setup interval, then raises `ce2` and recovers as in R3.
- R9: A `wake_req` while running and a `pd_req` while sleeping are discarded. Neither has any later effect.
- R10: With `alt_boot`=1, `ce2` is 1 for the power-up interval. This is followed by one full entry (setup, hold) and an exit setup with no wake request, then the R3 recovery.
- R11: When supply-good goes low, the block returns to the reset output values at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| supply_ok | input | 1 | Memory supply is within range |
| alt_boot | input | 1 | Select start-up method with second enable held high |
| pd_req | input | 1 | Host request to enter low power (pulse) |
| wake_req | input | 1 | Host request to leave low power (pulse) |
| bus_idle | input | 1 | Access controller grant: no access in flight, data bus released |
| host_ce1_n | input | 1 | First enable from the access controller, passed through when ready |
| ce1_n | output | 1 | First chip enable to the memory, active low |
| ce2 | output | 1 | Second chip enable to the memory, low selects low power |
| ready | output | 1 | Memory may be accessed |
| sleeping | output | 1 | Memory is parked in low power awaiting wake |

## Verification
The bench aims at the interval edges. It samples the cycle before and the cycle of each enable change. An off-by-one in the shared counter load would show as `ce2` or `ready` moving a cycle early or late. A power-down request raised while the bus is busy must wait: a design that ignored the idle grant would drop `ready` during an access. A wake raised during the entry hold must neither cut the hold short nor be lost; the wrong designs either raise `ce2` too early or sleep forever. Stray wake and power-down requests must not be remembered, or the memory would re-sleep or exit on its own later. A second instance at a different clock parameter runs the same stimulus under the ordering and minimum-interval assertions.

// File: rtl/psram_pwr_pkg.sv
// Shared types and interval conversion for the pseudo-SRAM power sequencer.
// Assumes the clock frequency is an integer number of MHz.
package psram_pwr_pkg;

    typedef enum logic [2:0] {
        PS_OFF,
        PS_PU_HOLD,
        PS_ENTRY_SETUP,
        PS_LP_HOLD,
        PS_SLEEP,
        PS_EXIT_SETUP,
        PS_RECOVER,
        PS_RUN
    } pwr_state_e;

    // Nanoseconds to clock cycles, rounded up, at least one cycle.
    function automatic int ns_to_cyc(input int ns, input int mhz);
        int c;
        c = (ns * mhz + 999) / 1000;
        return (c < 1) ? 1 : c;
    endfunction

    // Microseconds to clock cycles, at least one cycle.
    function automatic int us_to_cyc(input int us, input int mhz);
        int c;
        c = us * mhz;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/psram_pwr_timer.sv
// Single shared down-counter for every sequencer interval.
// A load of N makes done rise after N cycles in the loading state,
// so a state entered with a load lasts exactly N cycles when it leaves on done.
// Assumes load_val >= 1.
module psram_pwr_timer #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          done
);

    logic [CW-1:0] cnt_q;

    // Load remaining-cycle count or count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val - CW'(1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CW'(1);
        end
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/psram_pwr_req.sv
// Holds host power-down and wake requests until the sequencer takes
// or discards them. A request and a discard in the same cycle discard.
module psram_pwr_req (
    input  logic clk,
    input  logic rst_n,
    input  logic pd_req,
    input  logic wake_req,
    input  logic pd_take,
    input  logic pd_drop,
    input  logic wake_take,
    input  logic wake_drop,
    output logic pd_pend,
    output logic wake_pend
);

    // Power-down request flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pd_pend <= 1'b0;
        end else if (pd_take || pd_drop) begin
            pd_pend <= 1'b0;
        end else if (pd_req) begin
            pd_pend <= 1'b1;
        end
    end

    // Wake request flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wake_pend <= 1'b0;
        end else if (wake_take || wake_drop) begin
            wake_pend <= 1'b0;
        end else if (wake_req) begin
            wake_pend <= 1'b1;
        end
    end

endmodule

// File: rtl/psram_pwr_fsm.sv
// Power-state controller. Walks power-up, low-power entry, sleep, exit
// and recovery, loading the shared timer on every timed transition.
// Pin levels are registered from the next state, so they change
// exactly on the edge the state changes and never glitch.
// Assumes all *_CYC parameters are >= 1 and fit in CW bits.
module psram_pwr_fsm
    import psram_pwr_pkg::*;
#(
    parameter int CW       = 16,
    parameter int HOLD_CYC = 5000,
    parameter int REC_CYC  = 35000,
    parameter int SET_CYC  = 1,
    parameter int LPH_CYC  = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          supply_ok,
    input  logic          alt_boot,
    input  logic          bus_idle,
    input  logic          pd_pend,
    input  logic          wake_pend,
    input  logic          tmr_done,
    output logic          tmr_load,
    output logic [CW-1:0] tmr_val,
    output logic          pd_take,
    output logic          pd_drop,
    output logic          wake_take,
    output logic          wake_drop,
    output logic          ce2_o,
    output logic          ready_o,
    output logic          sleeping_o
);

    localparam logic [CW-1:0] HOLD_V = CW'(HOLD_CYC);
    localparam logic [CW-1:0] REC_V  = CW'(REC_CYC);
    localparam logic [CW-1:0] SET_V  = CW'(SET_CYC);
    localparam logic [CW-1:0] LPH_V  = CW'(LPH_CYC);

    pwr_state_e state_q, state_d;
    logic       boot_q, boot_d;
    logic       ce2_d;

    // Next-state, timer load and request bookkeeping.
    always_comb begin
        state_d   = state_q;
        boot_d    = boot_q;
        tmr_load  = 1'b0;
        tmr_val   = SET_V;
        pd_take   = 1'b0;
        wake_take = 1'b0;
        unique case (state_q)
            PS_OFF: begin
                boot_d = alt_boot;
                if (supply_ok) begin
                    state_d  = PS_PU_HOLD;
                    tmr_load = 1'b1;
                    tmr_val  = HOLD_V;
                end
            end
            PS_PU_HOLD: begin
                if (tmr_done) begin
                    tmr_load = 1'b1;
                    if (boot_q) begin
                        state_d = PS_ENTRY_SETUP;
                        tmr_val = SET_V;
                    end else begin
                        state_d = PS_RECOVER;
                        tmr_val = REC_V;
                    end
                end
            end
            PS_ENTRY_SETUP: begin
                if (tmr_done) begin
                    state_d  = PS_LP_HOLD;
                    tmr_load = 1'b1;
                    tmr_val  = LPH_V;
                end
            end
            PS_LP_HOLD: begin
                if (tmr_done) begin
                    if (boot_q) begin
                        state_d  = PS_EXIT_SETUP;
                        tmr_load = 1'b1;
                        tmr_val  = SET_V;
                    end else begin
                        state_d = PS_SLEEP;
                    end
                end
            end
            PS_SLEEP: begin
                if (wake_pend) begin
                    state_d   = PS_EXIT_SETUP;
                    wake_take = 1'b1;
                    tmr_load  = 1'b1;
                    tmr_val   = SET_V;
                end
            end
            PS_EXIT_SETUP: begin
                if (tmr_done) begin
                    state_d  = PS_RECOVER;
                    tmr_load = 1'b1;
                    tmr_val  = REC_V;
                end
            end
            PS_RECOVER: begin
                if (tmr_done) begin
                    state_d = PS_RUN;
                    boot_d  = 1'b0;
                end
            end
            PS_RUN: begin
                if (pd_pend && bus_idle) begin
                    state_d  = PS_ENTRY_SETUP;
                    pd_take  = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = SET_V;
                end
            end
            default: state_d = PS_OFF;
        endcase
        if (!supply_ok) begin
            state_d  = PS_OFF;
            tmr_load = 1'b0;
        end
    end

    assign pd_drop   = (state_q == PS_SLEEP) || (state_q == PS_OFF);
    assign wake_drop = (state_q == PS_RUN)   || (state_q == PS_OFF);

    // Second-enable level that belongs to the next state.
    always_comb begin
        unique case (state_d)
            PS_PU_HOLD:                  ce2_d = boot_d;
            PS_ENTRY_SETUP:              ce2_d = 1'b1;
            PS_RECOVER, PS_RUN:          ce2_d = 1'b1;
            default:                     ce2_d = 1'b0;
        endcase
    end

    // State, boot-method flag and registered pin levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= PS_OFF;
            boot_q     <= 1'b0;
            ce2_o      <= 1'b0;
            ready_o    <= 1'b0;
            sleeping_o <= 1'b0;
        end else begin
            state_q    <= state_d;
            boot_q     <= boot_d;
            ce2_o      <= ce2_d;
            ready_o    <= (state_d == PS_RUN);
            sleeping_o <= (state_d == PS_SLEEP);
        end
    end

endmodule

// File: rtl/psram_pwr_seq.sv
// Top of the pseudo-SRAM power-state sequencer. Converts the time
// parameters to cycle counts, sizes the shared timer and hands the
// first enable to the access controller only while ready is high.
// Assumes supply_ok and the request inputs are synchronous to clk.
module psram_pwr_seq
    import psram_pwr_pkg::*;
#(
    parameter int CLK_MHZ      = 100,
    parameter int PWRUP_LOW_US = 50,
    parameter int RECOVER_US   = 350,
    parameter int CE1_SETUP_NS = 10,
    parameter int LP_HOLD_NS   = 70
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    input  logic alt_boot,
    input  logic pd_req,
    input  logic wake_req,
    input  logic bus_idle,
    input  logic host_ce1_n,
    output logic ce1_n,
    output logic ce2,
    output logic ready,
    output logic sleeping
);

    localparam int HOLD_CYC = us_to_cyc(PWRUP_LOW_US, CLK_MHZ);
    localparam int REC_CYC  = us_to_cyc(RECOVER_US, CLK_MHZ);
    localparam int SET_CYC  = ns_to_cyc(CE1_SETUP_NS, CLK_MHZ);
    localparam int LPH_CYC  = ns_to_cyc(LP_HOLD_NS, CLK_MHZ);
    localparam int MAX_CYC  = max2(max2(HOLD_CYC, REC_CYC), max2(SET_CYC, LPH_CYC));
    localparam int CW       = $clog2(MAX_CYC + 1);

    logic          tmr_load, tmr_done;
    logic [CW-1:0] tmr_val;
    logic          pd_pend, wake_pend;
    logic          pd_take, pd_drop, wake_take, wake_drop;

    psram_pwr_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    psram_pwr_req u_req (
        .clk       (clk),
        .rst_n     (rst_n),
        .pd_req    (pd_req),
        .wake_req  (wake_req),
        .pd_take   (pd_take),
        .pd_drop   (pd_drop),
        .wake_take (wake_take),
        .wake_drop (wake_drop),
        .pd_pend   (pd_pend),
        .wake_pend (wake_pend)
    );

    psram_pwr_fsm #(
        .CW       (CW),
        .HOLD_CYC (HOLD_CYC),
        .REC_CYC  (REC_CYC),
        .SET_CYC  (SET_CYC),
        .LPH_CYC  (LPH_CYC)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .supply_ok  (supply_ok),
        .alt_boot   (alt_boot),
        .bus_idle   (bus_idle),
        .pd_pend    (pd_pend),
        .wake_pend  (wake_pend),
        .tmr_done   (tmr_done),
        .tmr_load   (tmr_load),
        .tmr_val    (tmr_val),
        .pd_take    (pd_take),
        .pd_drop    (pd_drop),
        .wake_take  (wake_take),
        .wake_drop  (wake_drop),
        .ce2_o      (ce2),
        .ready_o    (ready),
        .sleeping_o (sleeping)
    );

    // First enable: host-owned while ready, otherwise held deasserted.
    assign ce1_n = ready ? host_ce1_n : 1'b1;

endmodule

// File: rtl/psram_pwr_chk.sv
// Protocol checker for psram_pwr_seq: enable ordering and minimum
// interval lengths, measured with run-length counters in cycles.
module psram_pwr_chk
    import psram_pwr_pkg::*;
#(
    parameter int CLK_MHZ      = 100,
    parameter int RECOVER_US   = 350,
    parameter int CE1_SETUP_NS = 10,
    parameter int LP_HOLD_NS   = 70
) (
    input logic clk,
    input logic rst_n,
    input logic supply_ok,
    input logic ce1_n,
    input logic ce2,
    input logic ready,
    input logic sleeping
);

    localparam int REC_CYC = us_to_cyc(RECOVER_US, CLK_MHZ);
    localparam int SET_CYC = ns_to_cyc(CE1_SETUP_NS, CLK_MHZ);
    localparam int LPH_CYC = ns_to_cyc(LP_HOLD_NS, CLK_MHZ);
    localparam int RW      = $clog2(REC_CYC + 2) + 1;
    localparam logic [RW-1:0] SAT = '1;

    logic [RW-1:0] ce1_hi_run, ce2_lo_run, rec_run;
    logic          ce2_prev, lp_flag;

    // Run-length counters of pin levels, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ce1_hi_run <= '0;
            ce2_lo_run <= '0;
            rec_run    <= '0;
            ce2_prev   <= 1'b0;
            lp_flag    <= 1'b0;
        end else begin
            ce1_hi_run <= !ce1_n ? '0 : (ce1_hi_run == SAT ? SAT : ce1_hi_run + RW'(1));
            ce2_lo_run <= ce2 ? '0 : (ce2_lo_run == SAT ? SAT : ce2_lo_run + RW'(1));
            rec_run    <= !(ce2 && ce1_n) ? '0 : (rec_run == SAT ? SAT : rec_run + RW'(1));
            ce2_prev   <= ce2;
            if (!supply_ok)            lp_flag <= 1'b0;
            else if (ce2_prev && !ce2) lp_flag <= 1'b1;
            else if (!ce2_prev && ce2) lp_flag <= 1'b0;
        end
    end

    AST_CE2_RISE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ce2) |-> ce1_n); // R4
    AST_CE2_FALL_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ce2) && supply_ok) |-> (ce1_hi_run >= RW'(SET_CYC))); // R4
    AST_LP_HOLD_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ce2) && lp_flag) |-> (ce2_lo_run >= RW'(LPH_CYC))); // R7
    AST_RECOVERY_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> (rec_run >= RW'(REC_CYC))); // R3
    AST_READY_PINS: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> ce2); // R5
    AST_NOT_READY_CE1: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> ce1_n); // R5
    AST_SLEEP_PINS: assert property (@(posedge clk) disable iff (!rst_n)
        sleeping |-> (!ce2 && ce1_n && !ready)); // R7
    AST_SUPPLY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> (!ready && !sleeping)); // R11

endmodule

bind psram_pwr_seq psram_pwr_chk #(
    .CLK_MHZ      (CLK_MHZ),
    .RECOVER_US   (RECOVER_US),
    .CE1_SETUP_NS (CE1_SETUP_NS),
    .LP_HOLD_NS   (LP_HOLD_NS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .supply_ok (supply_ok),
    .ce1_n     (ce1_n),
    .ce2       (ce2),
    .ready     (ready),
    .sleeping  (sleeping)
);

// File: tb/sim_psram_pwr_seq.sv
`timescale 1ns/1ps
module sim_psram_pwr_seq;

    // u0 timing: 200 MHz, 2 us power-up hold, 3 us recovery, 10 ns setup, 70 ns hold.
    localparam int N = 400;  // 2 us * 200
    localparam int M = 600;  // 3 us * 200
    localparam int S = 2;    // ceil(10 * 200 / 1000)
    localparam int H = 14;   // ceil(70 * 200 / 1000)

    typedef struct packed {
        logic sup, pd, wake, idle, host;
        int   cyc;
        logic [3:0] exp;   // {ce1_n, ce2, ready, sleeping}
        logic [3:0] req;
    } row_t;

    localparam int NROW = 33;
    localparam row_t TBL [0:NROW-1] = '{
        '{1'b0,1'b0,1'b0,1'b1,1'b1, 3,   4'b1000, 4'd1},  // R1 no supply yet
        '{1'b1,1'b0,1'b0,1'b1,1'b1, N,   4'b1000, 4'd2},  // R2 last low cycle
        '{1'b1,1'b0,1'b0,1'b1,1'b1, 1,   4'b1100, 4'd2},  // R2 ce2 rises
        '{1'b1,1'b0,1'b0,1'b1,1'b1, M-1, 4'b1100, 4'd3},  // R3 last recovery cycle
        '{1'b1,1'b0,1'b0,1'b1,1'b1, 1,   4'b1110, 4'd3},  // R3 ready rises
        '{1'b1,1'b0,1'b0,1'b1,1'b0, 1,   4'b0110, 4'd5},  // R5 host owns ce1
        '{1'b1,1'b1,1'b0,1'b0,1'b0, 1,   4'b0110, 4'd6},  // R6 request, bus busy
        '{1'b1,1'b0,1'b0,1'b0,1'b0, 20,  4'b0110, 4'd6},  // R6 waits for grant
        '{1'b1,1'b0,1'b0,1'b1,1'b0, 1,   4'b1100, 4'd6},  // R6 grant starts entry
        '{1'b1,1'b0,1'b0,1'b1,1'b0, S-1, 4'b1100, 4'd7},  // R7 setup last cycle
        '{1'b1,1'b0,1'b0,1'b1,1'b0, 1,   4'b1000, 4'd7},  // R7 ce2 falls
        '{1'b1,1'b0,1'b1,1'b1,1'b0, 1,   4'b1000, 4'd8},  // R8 wake during hold
        '{1'b1,1'b0,1'b0,1'b1,1'b0, H-2, 4'b1000, 4'd8},  // R8 hold not cut short
        '{1'b1,1'b0,1'b0,1'b1,1'b0, 1,   4'b1001, 4'd8},  // R8 sleep after hold
        '{1'b1,1'b0,1'b0,1'b1,1'b0, 1,   4'b1000, 4'd8},  // R8 deferred wake taken
        '{1'b1,1'b0,1'b0,1'b1,1'b0, S-1, 4'b1000, 4'd8},  // R8 exit setup
        '{1'b1,1'b0,1'b0,1'b1,1'b0, 1,   4'b1100, 4'd8},  // R8 ce2 rises
        '{1'b1,1'b0,1'b0,1'b1,1'b0, M-1, 4'b1100, 4'd3},  // R3 recovery after wake
        '{1'b1,1'b0,1'b0,1'b1,1'b1, 1,   4'b1110, 4'd3},  // R3 ready again
        '{1'b1,1'b0,1'b1,1'b1,1'b1, 1,   4'b1110, 4'd9},  // R9 wake while running
        '{1'b1,1'b1,1'b0,1'b1,1'b1, 1,   4'b1110, 4'd6},  // R6 request latched
        '{1'b1,1'b0,1'b0,1'b1,1'b1, 1,   4'b1100, 4'd7},  // R7 entry setup
        '{1'b1,1'b0,1'b0,1'b1,1'b1, S,   4'b1000, 4'd7},  // R7 hold
        '{1'b1,1'b0,1'b0,1'b1,1'b1, H,   4'b1001, 4'd7},  // R7 sleeping
        '{1'b1,1'b0,1'b0,1'b1,1'b1, 40,  4'b1001, 4'd9},  // R9 stray wake forgotten
        '{1'b1,1'b1,1'b0,1'b1,1'b1, 1,   4'b1001, 4'd9},  // R9 pd while asleep
        '{1'b1,1'b0,1'b1,1'b1,1'b1, 1,   4'b1001, 4'd8},  // R8 wake latched
        '{1'b1,1'b0,1'b0,1'b1,1'b1, 1,   4'b1000, 4'd8},  // R8 exit setup
        '{1'b1,1'b0,1'b0,1'b1,1'b1, S,   4'b1100, 4'd8},  // R8 ce2 rises
        '{1'b1,1'b0,1'b0,1'b1,1'b1, M,   4'b1110, 4'd3},  // R3 ready
        '{1'b1,1'b0,1'b0,1'b1,1'b1, 30,  4'b1110, 4'd9},  // R9 pd in sleep forgotten
        '{1'b0,1'b0,1'b0,1'b1,1'b1, 1,   4'b1000, 4'd11}, // R11 supply lost
        '{1'b0,1'b0,1'b0,1'b1,1'b1, 5,   4'b1000, 4'd11}  // R11 stays off
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic supply_ok = 1'b0, alt_boot = 1'b0, pd_req = 1'b0, wake_req = 1'b0;
    logic bus_idle = 1'b1, host_ce1_n = 1'b1;
    logic ce1_n, ce2, ready, sleeping;
    logic x_ce1_n, x_ce2, x_ready, x_sleeping;
    int   checks = 0, errors = 0;
    logic finished = 1'b0;

    always #2.5 clk = ~clk;

    psram_pwr_seq #(
        .CLK_MHZ(200), .PWRUP_LOW_US(2), .RECOVER_US(3),
        .CE1_SETUP_NS(10), .LP_HOLD_NS(70)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .alt_boot(alt_boot),
        .pd_req(pd_req), .wake_req(wake_req), .bus_idle(bus_idle),
        .host_ce1_n(host_ce1_n), .ce1_n(ce1_n), .ce2(ce2), .ready(ready),
        .sleeping(sleeping)
    );

    // Second clock parameter: exercised only through its bound checker.
    psram_pwr_seq #(
        .CLK_MHZ(40), .PWRUP_LOW_US(2), .RECOVER_US(3),
        .CE1_SETUP_NS(10), .LP_HOLD_NS(70)
    ) u1 (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .alt_boot(alt_boot),
        .pd_req(pd_req), .wake_req(wake_req), .bus_idle(bus_idle),
        .host_ce1_n(host_ce1_n), .ce1_n(x_ce1_n), .ce2(x_ce2), .ready(x_ready),
        .sleeping(x_sleeping)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input string tag, input logic [3:0] exp);
        logic [3:0] got;
        got = {ce1_n, ce2, ready, sleeping};
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: {ce1_n,ce2,ready,sleeping} got %b expected %b at %0t",
                     tag, got, exp, $time);
        end
    endtask

    task automatic summary();
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        // R1: state while reset is held, with supply already good.
        supply_ok = 1'b1;
        step(3);
        check("R1 in reset", 4'b1000);
        supply_ok = 1'b0;
        step(1);
        rst_n = 1'b1;
        step(2);
        check("R1 after reset", 4'b1000);

        // Vector table: normal boot, power-down, wake, stray requests, supply loss.
        for (int i = 0; i < NROW; i++) begin
            supply_ok  = TBL[i].sup;
            pd_req     = TBL[i].pd;
            wake_req   = TBL[i].wake;
            bus_idle   = TBL[i].idle;
            host_ce1_n = TBL[i].host;
            step(1);
            pd_req   = 1'b0;
            wake_req = 1'b0;
            if (TBL[i].cyc > 1) step(TBL[i].cyc - 1);
            check($sformatf("R%0d row %0d", TBL[i].req, i), TBL[i].exp);
        end

        // R10: alternative start-up with second enable held high.
        rst_n = 1'b0; alt_boot = 1'b1; supply_ok = 1'b0;
        step(2);
        rst_n = 1'b1;
        step(2);
        check("R10 off before supply", 4'b1000);
        supply_ok = 1'b1;
        step(1);
        check("R10 ce2 high at power-up", 4'b1100);
        step(N - 1);
        check("R10 end of power-up hold", 4'b1100);
        step(1);
        check("R10 entry setup", 4'b1100);
        step(S - 1);
        check("R10 entry setup last", 4'b1100);
        step(1);
        check("R10 ce2 low", 4'b1000);
        step(H);
        check("R10 exit setup without wake", 4'b1000);
        step(S);
        check("R10 ce2 rises", 4'b1100);
        step(M - 1);
        check("R10 recovery last", 4'b1100);
        step(1);
        check("R10 ready", 4'b1110);

        // R1: reset while running.
        rst_n = 1'b0;
        step(1);
        check("R1 reset while running", 4'b1000);
        rst_n = 1'b1;
        alt_boot = 1'b0;
        supply_ok = 1'b0;
        step(2);

        finished = 1'b1;
        summary();
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, got timeout expected completion");
            summary();
            $finish;
        end
    end

endmodule